// File: doc/BRIEF.md
# Sprite Pixel Compositor

This block builds the final colour of each display pixel. Every cycle it takes the current 2-bit shape code and on-flag of each hardware sprite, the background bitmap pixel with its 2-bit depth value, and the blank and border flags. It returns one registered 15-bit RGB value. Sprite shapes and scanline timing come from elsewhere. The compositor only resolves which layer is visible and which colour that layer shows.

Sprites are ranked by number, and sprite 0 sits in front. A sprite can be chained to the next higher sprite so that two or three neighbours pool their codes into one 6-bit index into a shared 63-colour bank. A background depth value can hide a sprite. Palette entries can also make a sprite invert the background, blend half-and-half with it, or blink in step with a frame counter that advances on a per-frame pulse. The palette is loaded through a simple synchronous write port.

Top module: `sprite_compositor`

## Requirements
- R1: While blank_i is 1, rgb_o is 0 in the following cycle, whatever the other inputs are.
- R2: While border_i is 1 and blank_i is 0, rgb_o is border_rgb_i in the following cycle, whatever the sprite inputs are.
- R3: When no sprite is visible at the pixel, rgb_o is bg_rgb_i.
- R4: The effective code of sprite n is spr_code_i[2n+1:2n] if spr_on_i[n] is 1, and 0 otherwise. Code 0 is transparent. An unlinked sprite n with effective code c reads palette address n*4+c. A palette write stores pal_wdata_i at pal_addr_i at the clock edge.
- R5: When several sprites are visible at the pixel, the lowest-numbered one supplies the colour.
- R6: spr_link_i[k]=1 joins sprite k+1 to the group of sprite k, and a group holds at most three sprites. In a chain of set link bits, the fourth sprite starts a new group. A group's lowest sprite (its head) is the only member that is drawn. It has priority at its own position, and it reads palette address 64 + {c2,c1,c0}, where c0 is the head's effective code, c1 is that of the next sprite and c2 is that of the third sprite (0 if there is none). The group is transparent when all three codes are 0.
- R7: A sprite is hidden at a pixel when bg_z_i is less than its depth spr_z_i[2n+1:2n]. The depth of the group head applies. A hidden sprite lets lower-priority sprites through.
- R8: Palette entry layout: bits 14:0 colour, bit 15 reverse, bit 16 blend, bit 17 flash, bits 19:18 flash rate. When the winning entry has reverse set, the output is bg_rgb_i XOR 15'h7FFF.
- R9: When the winning entry has blend set and reverse clear, each 5-bit channel of the output is (sprite + background) >> 1. Reverse takes precedence over blend.
- R10: A 6-bit frame counter starts at 0 at reset and increments once per cycle in which frame_tick_i is 1. An entry with flash set is treated as transparent unless counter bit (2 + rate) is 1.
- R11: rgb_o is a register with one cycle of latency from the inputs, and it is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pal_we_i | input | 1 | Palette write enable |
| pal_addr_i | input | 7 | Palette write address |
| pal_wdata_i | input | 20 | Palette entry to write |
| frame_tick_i | input | 1 | One pulse per frame, advances the frame counter |
| spr_code_i | input | 2*NUM_SPR | Per-sprite 2-bit pixel codes |
| spr_on_i | input | NUM_SPR | Per-sprite on-flag at this pixel |
| spr_link_i | input | NUM_SPR-1 | Bit k joins sprite k+1 to sprite k |
| spr_z_i | input | 2*NUM_SPR | Per-sprite 2-bit depth |
| bg_rgb_i | input | 15 | Background pixel colour |
| bg_z_i | input | 2 | Background pixel depth |
| blank_i | input | 1 | Blanking interval |
| border_i | input | 1 | Border region |
| border_rgb_i | input | 15 | Border colour |
| rgb_o | output | 15 | Composited pixel, registered |

## Verification
Directed pixels cover the following cases separately: a lone sprite, two overlapping sprites, the on-flag against the code, two-sprite and three-sprite groups, and a four-long link chain that must split. Depth cases put a hidden front sprite over a visible rear one, so that hiding shows up as fall-through and not as plain background. Reverse, blend and flash entries are each tried alone, and the flash entry is tried both before and after the frame counter reaches its rate bit. A long run with a fixed seed then uses random codes, on-flags, sparse links, depths and palette attributes. It compares every pixel with a bench model, which catches errors in the interaction between priority, linking and attribute handling.

// File: rtl/sprc_pkg.sv
package sprc_pkg;
  localparam int RGB_W      = 15;
  localparam int PAL_AW     = 7;
  localparam int FLASH_BASE = 2;
  localparam int FCNT_W     = FLASH_BASE + 4;

  typedef struct packed {
    logic [1:0]       rate;
    logic             flash;
    logic             alpha;
    logic             rev;
    logic [RGB_W-1:0] rgb;
  } pal_ent_t;

  localparam int ENT_W = $bits(pal_ent_t);
endpackage

// File: rtl/sprc_palette.sv
module sprc_palette
  import sprc_pkg::*;
#(
  parameter int NUM_RD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAL_AW-1:0] waddr_i,
  input  pal_ent_t          wdata_i,
  input  logic [PAL_AW-1:0] raddr_i [NUM_RD],
  output pal_ent_t          rdata_o [NUM_RD]
);
  localparam int DEPTH = 1 << PAL_AW;

  pal_ent_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end

  // R4
  pal_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/sprc_link.sv
module sprc_link
  import sprc_pkg::*;
#(
  parameter int NUM_SPR = 8
) (
  input  logic [2*NUM_SPR-1:0] code_i,
  input  logic [NUM_SPR-1:0]   on_i,
  input  logic [NUM_SPR-2:0]   link_i,
  output logic [PAL_AW-1:0]    addr_o [NUM_SPR],
  output logic [NUM_SPR-1:0]   lit_o
);
  localparam int PAD = NUM_SPR + 2;

  logic [1:0] code_eff [PAD];
  logic [1:0] depth    [PAD];

  always_comb begin
    for (int n = 0; n < PAD; n++) begin
      code_eff[n] = 2'b00;
      depth[n]    = 2'd0;
    end
    for (int n = 0; n < NUM_SPR; n++) begin
      code_eff[n] = on_i[n] ? code_i[2*n +: 2] : 2'b00;
    end
    // position inside a group: 0 = head, chain cut after three members
    for (int n = 1; n < NUM_SPR; n++) begin
      if (link_i[n-1]) depth[n] = (depth[n-1] == 2'd2) ? 2'd0 : depth[n-1] + 2'd1;
      else             depth[n] = 2'd0;
    end
    for (int n = 0; n < NUM_SPR; n++) begin
      logic       m1, m2;
      logic [1:0] hi;
      logic [5:0] comb;
      m1   = (depth[n+1] == 2'd1);
      m2   = m1 && (depth[n+2] == 2'd2);
      hi   = m2 ? code_eff[n+2] : 2'b00;
      if (m1) begin
        comb      = {hi, code_eff[n+1], code_eff[n]};
        addr_o[n] = {1'b1, comb};
      end else begin
        comb      = {4'd0, code_eff[n]};
        addr_o[n] = PAL_AW'(n * 4) | {5'd0, code_eff[n]};
      end
      lit_o[n] = (depth[n] == 2'd0) && (comb != 6'd0);
    end
  end
endmodule

// File: rtl/sprc_select.sv
module sprc_select
  import sprc_pkg::*;
#(
  parameter int NUM_SPR = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SPR-1:0]   lit_i,
  input  pal_ent_t             ent_i [NUM_SPR],
  input  logic [2*NUM_SPR-1:0] z_i,
  input  logic [1:0]           bg_z_i,
  input  logic [FCNT_W-1:0]    fcnt_i,
  output logic                 hit_o,
  output pal_ent_t             ent_o
);
  logic [NUM_SPR-1:0] cand;
  logic [NUM_SPR-1:0] win;
  logic [1:0]         sel_z;

  always_comb begin
    for (int n = 0; n < NUM_SPR; n++) begin
      cand[n] = lit_i[n]
              && (z_i[2*n +: 2] <= bg_z_i)
              && (!ent_i[n].flash || fcnt_i[FLASH_BASE + int'(ent_i[n].rate)]);
    end
    win   = '0;
    hit_o = 1'b0;
    ent_o = '0;
    sel_z = 2'd0;
    // walk from the back so the lowest index wins
    for (int n = NUM_SPR - 1; n >= 0; n--) begin
      if (cand[n]) begin
        win    = '0;
        win[n] = 1'b1;
        hit_o  = 1'b1;
        ent_o  = ent_i[n];
        sel_z  = z_i[2*n +: 2];
      end
    end
  end

  // R5
  win_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win) && (hit_o == (win != '0)));

  // R7
  depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> sel_z <= bg_z_i);
endmodule

// File: rtl/sprite_compositor.sv
module sprite_compositor
  import sprc_pkg::*;
#(
  parameter int NUM_SPR = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pal_we_i,
  input  logic [6:0]           pal_addr_i,
  input  logic [19:0]          pal_wdata_i,
  input  logic                 frame_tick_i,
  input  logic [2*NUM_SPR-1:0] spr_code_i,
  input  logic [NUM_SPR-1:0]   spr_on_i,
  input  logic [NUM_SPR-2:0]   spr_link_i,
  input  logic [2*NUM_SPR-1:0] spr_z_i,
  input  logic [14:0]          bg_rgb_i,
  input  logic [1:0]           bg_z_i,
  input  logic                 blank_i,
  input  logic                 border_i,
  input  logic [14:0]          border_rgb_i,
  output logic [14:0]          rgb_o
);
  localparam int CH_W  = RGB_W / 3;
  localparam int N_CH  = RGB_W / CH_W;

  logic [PAL_AW-1:0] addr [NUM_SPR];
  pal_ent_t          ent  [NUM_SPR];
  logic [NUM_SPR-1:0] lit;
  logic              hit;
  pal_ent_t          win_ent;
  logic [FCNT_W-1:0] fcnt_q;
  logic [RGB_W-1:0]  blend, pix_d, rgb_q;

  sprc_link #(.NUM_SPR(NUM_SPR)) u_link (
    .code_i (spr_code_i),
    .on_i   (spr_on_i),
    .link_i (spr_link_i),
    .addr_o (addr),
    .lit_o  (lit)
  );

  sprc_palette #(.NUM_RD(NUM_SPR)) u_pal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we_i),
    .waddr_i (pal_addr_i),
    .wdata_i (pal_ent_t'(pal_wdata_i)),
    .raddr_i (addr),
    .rdata_o (ent)
  );

  sprc_select #(.NUM_SPR(NUM_SPR)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lit_i  (lit),
    .ent_i  (ent),
    .z_i    (spr_z_i),
    .bg_z_i (bg_z_i),
    .fcnt_i (fcnt_q),
    .hit_o  (hit),
    .ent_o  (win_ent)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           fcnt_q <= '0;
    else if (frame_tick_i) fcnt_q <= fcnt_q + 1'b1;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_blend
    logic [CH_W:0] sum;
    assign sum = {1'b0, win_ent.rgb[ch*CH_W +: CH_W]} + {1'b0, bg_rgb_i[ch*CH_W +: CH_W]};
    assign blend[ch*CH_W +: CH_W] = sum[CH_W:1];
  end

  always_comb begin
    if (blank_i)           pix_d = '0;
    else if (border_i)     pix_d = border_rgb_i;
    else if (!hit)         pix_d = bg_rgb_i;
    else if (win_ent.rev)  pix_d = bg_rgb_i ^ {RGB_W{1'b1}};
    else if (win_ent.alpha) pix_d = blend;
    else                   pix_d = win_ent.rgb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_q <= '0;
    else         rgb_q <= pix_d;
  end

  assign rgb_o = rgb_q;

  // R1
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> rgb_o == '0);

  // R2
  border_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (border_i && !blank_i) |=> rgb_o == $past(border_rgb_i));

  // R3
  bg_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_i && !border_i && !hit) |=> rgb_o == $past(bg_rgb_i));

  // R8
  rev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_i && !border_i && hit && win_ent.rev) |=> rgb_o == ($past(bg_rgb_i) ^ 15'h7fff));

  // R10
  fcnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_i |=> fcnt_q == $past(fcnt_q) + 1'b1);

  // R10
  fcnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i |=> $stable(fcnt_q));
endmodule

// File: tb/sprite_compositor_test.sv
module sprite_compositor_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pal_we = 1'b0;
  logic [6:0] pal_addr = '0;
  logic [19:0] pal_wdata = '0;
  logic frame_tick = 1'b0;
  logic [2*N-1:0] spr_code = '0;
  logic [N-1:0] spr_on = '0;
  logic [N-2:0] spr_link = '0;
  logic [2*N-1:0] spr_z = '0;
  logic [14:0] bg_rgb = '0;
  logic [1:0] bg_z = 2'd3;
  logic blank = 1'b0, border = 1'b0;
  logic [14:0] border_rgb = '0;
  logic [14:0] rgb_o;

  logic [19:0] pal_m [128];
  logic [5:0] fcnt_m = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sprite_compositor #(.NUM_SPR(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pal_we_i(pal_we), .pal_addr_i(pal_addr),
    .pal_wdata_i(pal_wdata), .frame_tick_i(frame_tick), .spr_code_i(spr_code),
    .spr_on_i(spr_on), .spr_link_i(spr_link), .spr_z_i(spr_z), .bg_rgb_i(bg_rgb),
    .bg_z_i(bg_z), .blank_i(blank), .border_i(border), .border_rgb_i(border_rgb),
    .rgb_o(rgb_o)
  );

  function automatic logic [14:0] model();
    logic [1:0] c [N+2];
    logic [1:0] d [N+2];
    for (int n = 0; n < N + 2; n++) begin c[n] = 0; d[n] = 0; end
    for (int n = 0; n < N; n++) c[n] = spr_on[n] ? spr_code[2*n +: 2] : 2'b00;
    for (int n = 1; n < N; n++)
      d[n] = !spr_link[n-1] ? 2'd0 : (d[n-1] == 2'd2 ? 2'd0 : d[n-1] + 2'd1);
    if (blank) return 15'h0;
    if (border) return border_rgb;
    for (int n = 0; n < N; n++) begin
      logic [6:0] a;
      logic [5:0] idx;
      logic [19:0] e;
      if (d[n] != 0) continue;
      if (d[n+1] == 1) begin
        idx = {(d[n+2] == 2) ? c[n+2] : 2'b00, c[n+1], c[n]};
        a = 7'd64 + {1'b0, idx};
      end else begin
        idx = {4'd0, c[n]};
        a = 7'(n * 4 + int'(c[n]));
      end
      if (idx == 0) continue;
      if (bg_z < spr_z[2*n +: 2]) continue;
      e = pal_m[a];
      if (e[17] && !fcnt_m[2 + int'(e[19:18])]) continue;
      if (e[15]) return bg_rgb ^ 15'h7fff;
      if (e[16]) begin
        logic [14:0] r;
        for (int ch = 0; ch < 3; ch++) begin
          logic [5:0] s;
          s = {1'b0, e[ch*5 +: 5]} + {1'b0, bg_rgb[ch*5 +: 5]};
          r[ch*5 +: 5] = s[5:1];
        end
        return r;
      end
      return e[14:0];
    end
    return bg_rgb;
  endfunction

  task automatic check_pix(string tag);
    logic [14:0] exp;
    exp = model();
    @(posedge clk);
    #1;
    checks++;
    if (rgb_o !== exp) begin
      errors++;
      $display("FAIL %s: rgb_o=%h expected %h", tag, rgb_o, exp);
    end
    @(negedge clk);
  endtask

  task automatic pal_wr(input logic [6:0] a, input logic [19:0] v);
    pal_we = 1; pal_addr = a; pal_wdata = v;
    @(posedge clk); #1;
    pal_m[a] = v;
    @(negedge clk);
    pal_we = 0;
  endtask

  task automatic tick();
    frame_tick = 1;
    @(posedge clk); #1;
    fcnt_m = fcnt_m + 1;
    @(negedge clk);
    frame_tick = 0;
  endtask

  task automatic clear();
    spr_code = '0; spr_on = '0; spr_link = '0; spr_z = '0;
    bg_z = 2'd3; blank = 0; border = 0;
  endtask

  task automatic put(input int n, input logic [1:0] code, input logic [1:0] z);
    spr_on[n] = 1; spr_code[2*n +: 2] = code; spr_z[2*n +: 2] = z;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) pal_m[i] = '0;
    #1;
    // R11 reset value
    checks++;
    if (rgb_o !== 15'h0) begin errors++; $display("FAIL R11: rgb_o=%h expected 0000", rgb_o); end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    pal_wr(7'd1,  {5'b00000, 15'h1234});
    pal_wr(7'd11, {5'b00000, 15'h0abc});
    pal_wr(7'd21, {5'b00000, 15'h7001});
    pal_wr(7'd73, {5'b00000, 15'h2222});
    pal_wr(7'd91, {5'b00000, 15'h3333});
    pal_wr(7'd13, {5'b00001, 15'h0555});
    pal_wr(7'd17, {5'b00010, 15'h7fff});
    pal_wr(7'd25, {5'b00100, 15'h0f0f});

    clear(); bg_rgb = 15'h1357;
    check_pix("R3 no sprite");
    put(0, 2'd1, 0); check_pix("R4 sprite0 code1");
    spr_code[1:0] = 0; check_pix("R4 code0 transparent");
    spr_code[1:0] = 1; spr_on[0] = 0; check_pix("R4 on-flag off");
    clear(); put(2, 2'd3, 0); put(5, 2'd1, 0); check_pix("R5 lower index wins");
    blank = 1; check_pix("R1 blank");
    blank = 0; border = 1; border_rgb = 15'h4a4a; check_pix("R2 border");
    blank = 1; check_pix("R1 blank over border");
    clear(); spr_link[0] = 1; put(0, 2'd1, 0); put(1, 2'd2, 0); check_pix("R6 two linked");
    spr_code[1:0] = 0; check_pix("R6 member code only");
    clear(); spr_link[1:0] = 2'b11; put(0, 2'd3, 0); put(1, 2'd2, 0); put(2, 2'd1, 0);
    check_pix("R6 three linked");
    clear(); spr_link[2:0] = 3'b111; put(3, 2'd1, 0); check_pix("R6 fourth starts new group");
    put(0, 2'd1, 0); check_pix("R6 chain head in front");
    clear(); bg_rgb = 15'h2468; bg_z = 2'd1; put(0, 2'd1, 2'd2); check_pix("R7 hidden");
    put(5, 2'd1, 2'd0); check_pix("R7 falls through");
    bg_z = 2'd2; check_pix("R7 equal depth visible");
    clear(); put(3, 2'd1, 0); check_pix("R8 reverse");
    clear(); bg_rgb = 15'h0; put(4, 2'd1, 0); check_pix("R9 blend");
    bg_rgb = 15'h7fff; check_pix("R9 blend full");
    pal_wr(7'd17, {5'b00011, 15'h1111});
    check_pix("R9 reverse beats blend");
    clear(); put(6, 2'd1, 0); check_pix("R10 flash off");
    repeat (4) tick();
    check_pix("R10 flash on");

    for (int i = 0; i < 128; i++) pal_wr(7'(i), 20'($urandom));
    for (int it = 0; it < 4000; it++) begin
      logic [N-2:0] lk;
      spr_code = 16'($urandom);
      spr_on = 8'($urandom);
      lk = 7'($urandom) & 7'($urandom);
      spr_link = lk;
      spr_z = 16'($urandom);
      bg_z = 2'($urandom);
      bg_rgb = 15'($urandom);
      border_rgb = 15'($urandom);
      blank = ($urandom % 16) == 0;
      border = ($urandom % 16) == 0;
      check_pix("R4 R5 R6 R7 R8 R9 R10 random");
      if (it % 97 == 0) tick();
    end
    finish_run();
  end
endmodule